// File: doc/BRIEF.md
# Instrument Status Byte and Service Request Unit

This block holds the standard event register of an instrument control interface and builds the status byte from it. One-cycle event strobes (operation complete, query error, device-dependent error, execution error, command error and power-on) are caught in a sticky event register. A software-written enable mask selects which of those events count towards the event summary. Reading the event register returns its contents and clears it in the same cycle.

The status byte merges five level inputs and summaries: the error queue holding entries, the questionable summary, the output message being available, the enabled event summary and the operation summary. A request-service bit is set whenever any other status byte bit is set, and no mask can hide it. A service request output is raised when the request-service bit rises. It stays high until the status byte is read.

Top module: `svc_status_top`

## Requirements
- R1: After reset the event register holds 0x80 (only the power-on bit, bit 7, set), the enable mask is 0x00 and the service request output is low.
- R2: A strobe on event bit 0 (operation complete), 2 (query error), 3 (device-dependent error), 4 (execution error), 5 (command error) or 7 (power-on) sets that bit of the event register on the next clock edge. The bit stays set until an event-register read.
- R3: Event bits 1 and 6 always read 0, whatever is strobed. Enable mask bits 1 and 6 are forced to 0 on a write.
- R4: An event read returns the register value in that cycle and clears the register at the clock edge. An event strobed in the same cycle as the read is kept.
- R5: Status byte bit 5 is the OR over all bits of (event register AND enable mask).
- R6: Status byte bit 2 follows the error-queue-not-empty input, bit 3 the questionable summary, bit 4 message available and bit 7 the operation summary, all in the same cycle. Bits 0 and 1 are always 0.
- R7: Status byte bit 6 is 1 exactly when any other status byte bit is 1. It has no mask.
- R8: The service request output goes high one clock edge after status byte bit 6 changes from 0 to 1. It stays high until a clock edge with a status byte read. If a new 0-to-1 change of bit 6 coincides with the read, the output stays high.
- R9: An enable write takes effect at the next clock edge, and the written mask (with bits 1 and 6 forced to 0) is readable on the enable port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 8 | One-cycle event strobes, indexed by event bit position |
| enaWrite | input | 1 | Load the enable mask from enaData |
| enaData | input | 8 | New enable mask value |
| evtRead | input | 1 | Read-with-clear of the event register |
| errQueueBusy | input | 1 | Error queue is not empty |
| questSummary | input | 1 | Questionable summary |
| msgReady | input | 1 | Output message available |
| operSummary | input | 1 | Operation summary |
| stbRead | input | 1 | Status byte read; acknowledges the service request |
| evtValue | output | 8 | Current event register value |
| enaValue | output | 8 | Current enable mask |
| stbValue | output | 8 | Status byte |
| srqOut | output | 1 | Service request |

## Verification
The assertions assume that the level inputs change only between clock edges and that the strobes are single-cycle pulses sampled at the rising edge. The bench drives every input on the falling edge and holds it through the next rising edge, which keeps within these assumptions. The properties tie the request-service bit to its service request, treat event bits as sticky while no read occurs, and relate the event register after a read to the strobes seen in the read cycle. These hold only when the read and acknowledge strobes are exclusive to their own cycle, and the stimulus keeps to that.

// File: rtl/svc_status_pkg.sv
package svc_status_pkg;

  localparam int EVT_W = 8;
  localparam int STB_W = 8;

  // event register positions
  localparam int EV_OPC   = 0;
  localparam int EV_RQC   = 1;
  localparam int EV_QYE   = 2;
  localparam int EV_DDE   = 3;
  localparam int EV_EXE   = 4;
  localparam int EV_CME   = 5;
  localparam int EV_ZERO  = 6;
  localparam int EV_PON   = 7;

  // status byte positions
  localparam int SB_ERRQ  = 2;
  localparam int SB_QUES  = 3;
  localparam int SB_MAV   = 4;
  localparam int SB_ESUM  = 5;
  localparam int SB_RQS   = 6;
  localparam int SB_OPER  = 7;

  localparam logic [EVT_W-1:0] EVT_LIVE =
      EVT_W'((1 << EV_OPC) | (1 << EV_QYE) | (1 << EV_DDE) |
             (1 << EV_EXE) | (1 << EV_CME) | (1 << EV_PON));

  localparam logic [EVT_W-1:0] EVT_RESET = EVT_W'(1 << EV_PON);

  typedef struct packed {
    logic clrEvt;
    logic loadEna;
    logic ackSrq;
  } ctrlStrobe_t;

endpackage

// File: rtl/svc_status_dp.sv
module svc_status_dp
  import svc_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      ctl,
  input  logic [EVT_W-1:0] evtPulse,
  input  logic [EVT_W-1:0] enaData,
  input  logic             errQueueBusy,
  input  logic             questSummary,
  input  logic             msgReady,
  input  logic             operSummary,
  output logic [EVT_W-1:0] evtReg,
  output logic [EVT_W-1:0] enaReg,
  output logic [STB_W-1:0] stbVec,
  output logic             rqsBit
);

  logic [EVT_W-1:0] evtKeep;
  logic [EVT_W-1:0] evtNext;
  logic [EVT_W-1:0] evtHit;
  logic             eventSum;

  // per-bit sticky latch, unused positions tied off
  for (genvar b = 0; b < EVT_W; b++) begin : gEvt
    if (EVT_LIVE[b]) begin : gLive
      assign evtKeep[b] = ctl.clrEvt ? 1'b0 : evtReg[b];
      assign evtNext[b] = evtKeep[b] | evtPulse[b];
    end else begin : gDead
      assign evtKeep[b] = 1'b0;
      assign evtNext[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtReg <= EVT_RESET;
      enaReg <= '0;
    end else begin
      evtReg <= evtNext;
      if (ctl.loadEna) enaReg <= enaData & EVT_LIVE;
    end
  end

  assign evtHit   = evtReg & enaReg;
  assign eventSum = |evtHit;

  logic [STB_W-1:0] stbBase;

  always_comb begin
    stbBase           = '0;
    stbBase[SB_ERRQ]  = errQueueBusy;
    stbBase[SB_QUES]  = questSummary;
    stbBase[SB_MAV]   = msgReady;
    stbBase[SB_ESUM]  = eventSum;
    stbBase[SB_OPER]  = operSummary;
  end

  assign rqsBit = |stbBase;

  always_comb begin
    stbVec         = stbBase;
    stbVec[SB_RQS] = rqsBit;
  end

endmodule

// File: rtl/svc_status_ctrl.sv
module svc_status_ctrl
  import svc_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtRead,
  input  logic        enaWrite,
  input  logic        stbRead,
  input  logic        rqsBit,
  output ctrlStrobe_t ctl,
  output logic        srq
);

  logic rqsPrev;
  logic rqsRise;

  always_comb begin
    ctl.clrEvt  = evtRead;
    ctl.loadEna = enaWrite;
    ctl.ackSrq  = stbRead;
  end

  assign rqsRise = rqsBit & ~rqsPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rqsPrev <= 1'b0;
      srq     <= 1'b0;
    end else begin
      rqsPrev <= rqsBit;
      if (rqsRise)         srq <= 1'b1;
      else if (ctl.ackSrq) srq <= 1'b0;
    end
  end

endmodule

// File: rtl/svc_status_top.sv
module svc_status_top
  import svc_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [EVT_W-1:0] evtPulse,
  input  logic             enaWrite,
  input  logic [EVT_W-1:0] enaData,
  input  logic             evtRead,
  input  logic             errQueueBusy,
  input  logic             questSummary,
  input  logic             msgReady,
  input  logic             operSummary,
  input  logic             stbRead,
  output logic [EVT_W-1:0] evtValue,
  output logic [EVT_W-1:0] enaValue,
  output logic [STB_W-1:0] stbValue,
  output logic             srqOut
);

  ctrlStrobe_t ctl;
  logic        rqsBit;

  svc_status_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .evtRead  (evtRead),
    .enaWrite (enaWrite),
    .stbRead  (stbRead),
    .rqsBit   (rqsBit),
    .ctl      (ctl),
    .srq      (srqOut)
  );

  svc_status_dp uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .evtPulse     (evtPulse),
    .enaData      (enaData),
    .errQueueBusy (errQueueBusy),
    .questSummary (questSummary),
    .msgReady     (msgReady),
    .operSummary  (operSummary),
    .evtReg       (evtValue),
    .enaReg       (enaValue),
    .stbVec       (stbValue),
    .rqsBit       (rqsBit)
  );

endmodule

// File: rtl/svc_status_chk.sv
module svc_status_chk
  import svc_status_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [EVT_W-1:0] evtPulse,
  input logic             evtRead,
  input logic             stbRead,
  input logic [EVT_W-1:0] evtValue,
  input logic [EVT_W-1:0] enaValue,
  input logic [STB_W-1:0] stbValue,
  input logic             srqOut
);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (evtValue[EV_RQC] == 1'b0) && (evtValue[EV_ZERO] == 1'b0) &&
    (enaValue[EV_RQC] == 1'b0) && (enaValue[EV_ZERO] == 1'b0));

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !evtRead |=> ((evtValue & $past(evtValue)) == $past(evtValue)));

  a_r4_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    evtRead |=> (evtValue == ($past(evtPulse) & EVT_LIVE)));

  a_r6_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    stbValue[1:0] == 2'b00);

  a_r7_rqs_any: assert property (@(posedge clk) disable iff (!rstN)
    stbValue[SB_RQS] == (|(stbValue & ~STB_W'(1 << SB_RQS))));

  a_r8_rise_sets: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stbValue[SB_RQS]) |=> srqOut);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (srqOut && !stbRead) |=> srqOut);

endmodule

bind svc_status_top svc_status_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .evtPulse (evtPulse),
  .evtRead  (evtRead),
  .stbRead  (stbRead),
  .evtValue (evtValue),
  .enaValue (enaValue),
  .stbValue (stbValue),
  .srqOut   (srqOut)
);

// File: tb/svc_status_top_test.sv
module svc_status_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  // {evt, enaWr, enaVal, rdEvt, rdStb, lvl{errQ,ques,mav,oper},
  //  expEvt, expStb, expSrq, expEna}
  localparam logic [47:0] VEC [NVEC] = '{
    {8'h00,1'b0,8'h00,1'b0,1'b0,4'h0, 8'h80,8'h00,1'b0,8'h00}, // idle
    {8'h00,1'b1,8'h80,1'b0,1'b0,4'h0, 8'h80,8'h60,1'b0,8'h80}, // enable pon
    {8'h00,1'b0,8'h00,1'b0,1'b0,4'h0, 8'h80,8'h60,1'b1,8'h80}, // srq rises
    {8'h00,1'b0,8'h00,1'b1,1'b0,4'h0, 8'h00,8'h00,1'b1,8'h80}, // read clears
    {8'h00,1'b0,8'h00,1'b0,1'b1,4'h0, 8'h00,8'h00,1'b0,8'h80}, // ack
    {8'h01,1'b0,8'h00,1'b0,1'b0,4'h0, 8'h01,8'h00,1'b0,8'h80}, // opc masked
    {8'h00,1'b1,8'hFF,1'b0,1'b0,4'h0, 8'h01,8'h60,1'b0,8'hBD}, // enable all
    {8'h42,1'b0,8'h00,1'b0,1'b0,4'h0, 8'h01,8'h60,1'b1,8'hBD}, // dead bits
    {8'h00,1'b0,8'h00,1'b0,1'b0,4'h8, 8'h01,8'h64,1'b1,8'hBD}, // errq
    {8'h20,1'b0,8'h00,1'b1,1'b0,4'h7, 8'h20,8'hF8,1'b1,8'hBD}, // read+event
    {8'h00,1'b0,8'h00,1'b0,1'b1,4'h7, 8'h20,8'hF8,1'b0,8'hBD}, // ack, rqs held
    {8'h00,1'b0,8'h00,1'b1,1'b0,4'h0, 8'h00,8'h00,1'b0,8'hBD}, // all quiet
    {8'h00,1'b0,8'h00,1'b0,1'b0,4'h8, 8'h00,8'h44,1'b1,8'hBD}, // new rise
    {8'h00,1'b0,8'h00,1'b0,1'b0,4'h0, 8'h00,8'h00,1'b1,8'hBD}, // rqs drops
    {8'h00,1'b0,8'h00,1'b0,1'b1,4'h8, 8'h00,8'h44,1'b1,8'hBD}, // rise wins
    {8'h00,1'b0,8'h00,1'b0,1'b1,4'h8, 8'h00,8'h44,1'b0,8'hBD}  // ack
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] evtPulse = '0;
  logic       enaWrite = 1'b0;
  logic [7:0] enaData = '0;
  logic       evtRead = 1'b0;
  logic       errQueueBusy = 1'b0;
  logic       questSummary = 1'b0;
  logic       msgReady = 1'b0;
  logic       operSummary = 1'b0;
  logic       stbRead = 1'b0;
  logic [7:0] evtValue;
  logic [7:0] enaValue;
  logic [7:0] stbValue;
  logic       srqOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  svc_status_top uut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .enaWrite(enaWrite),
    .enaData(enaData), .evtRead(evtRead), .errQueueBusy(errQueueBusy),
    .questSummary(questSummary), .msgReady(msgReady),
    .operSummary(operSummary), .stbRead(stbRead), .evtValue(evtValue),
    .enaValue(enaValue), .stbValue(stbValue), .srqOut(srqOut)
  );

  task automatic check(input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    evtPulse = '0; enaWrite = 1'b0; enaData = '0; evtRead = 1'b0;
    stbRead = 1'b0;
  endtask

  task automatic applyReset();
    @(negedge clk);
    quiet();
    {errQueueBusy, questSummary, msgReady, operSummary} = 4'h0;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    applyReset();
    // R1 reset state
    check("R1 event", evtValue, 8'h80);
    check("R1 enable", enaValue, 8'h00);
    check("R1 srq", {7'd0, srqOut}, 8'h00);
    check("R6 stb after reset", stbValue, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [47:0] v;
      v = VEC[i];
      @(negedge clk);
      evtPulse = v[47:40];
      enaWrite = v[39];
      enaData  = v[38:31];
      evtRead  = v[30];
      stbRead  = v[29];
      {errQueueBusy, questSummary, msgReady, operSummary} = v[28:25];
      @(posedge clk);
      #1;
      check(v[30] ? "R4 event after read" : "R2 event", evtValue, v[24:17]);
      check("R6 status byte", stbValue, v[16:9]);
      check("R5 event summary", {7'd0, stbValue[5]}, {7'd0, v[14]});
      check("R7 request service", {7'd0, stbValue[6]}, {7'd0, v[15]});
      check("R8 srq", {7'd0, srqOut}, {7'd0, v[8]});
      check("R9 enable", enaValue, v[7:0]);
      @(negedge clk);
      quiet();
    end

    // R3: strobes on positions 1 and 6 only
    @(negedge clk);
    evtRead = 1'b1;
    @(negedge clk);
    quiet();
    evtPulse = 8'h42;
    @(negedge clk);
    quiet();
    check("R3 dead bits", evtValue, 8'h00);

    // R4: value visible during read, same-cycle event kept
    evtPulse = 8'h10;
    @(negedge clk);
    quiet();
    evtRead = 1'b1;
    evtPulse = 8'h08;
    #1;
    check("R4 read value", evtValue, 8'h10);
    @(negedge clk);
    quiet();
    check("R4 kept event", evtValue, 8'h08);

    // R2: every live bit latches
    evtPulse = 8'hBD;
    @(negedge clk);
    quiet();
    check("R2 all live", evtValue, 8'hBD);

    // R1: reset again restores state
    applyReset();
    check("R1 re-reset event", evtValue, 8'h80);
    check("R1 re-reset enable", enaValue, 8'h00);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule